// File: doc/BRIEF.md
# SPI Burst Exchange Engine

This block moves 32-bit words from a transmit queue onto an SPI link and gathers the returned bytes into 32-bit words in a receive queue. A programmable burst length decides how many bits go out before the engine either stops or, in chained mode, carries on into the next burst. Bytes always travel whole, so the programmed length is rounded up to a byte multiple. The first word of every burst carries only the odd remainder of the length (modulo 32), and every later word carries a full 32 bits.

Software-style control enters as a few fields: the burst length minus one, a channel select, a mask of channels acting as SPI master, a mask of per-channel chained-burst enables, and a control write that updates two bits. One bit, the immediate-start bit, makes every TX push start transmission. The other, the exchange bit, starts a transfer on its rising write. The engine reports a sticky transfer-complete flag and a sticky receive-overflow flag, both cleared by a one-cycle clear pulse. It also drops the exchange bit once the transmit queue runs dry.

The SPI side runs in mode 0 from a fixed divider of the system clock. The block has no slave support.

Top module: `spi_burst_engine`

## Requirements
- R1: The burst length in bits is `cfg_burst_m1 + 1` rounded up to the next multiple of 8 (for example 1..8 gives 8, 9..16 gives 16, 33 gives 40).
- R2: The first word taken at the start of a burst supplies (remaining burst bits mod 32) bits, or 32 bits when that remainder is zero. Later words in the same burst supply 32 bits. The remaining count carries across exchanges when a transfer ends mid-burst.
- R3: A word of N bits is sent as N/8 bytes, starting at bits [N-1:N-8] and moving down. Each byte goes most-significant bit first. Received bytes are shifted into the received word from the low end, so a partial word is zero-extended.
- R4: SPI mode 0. `sclk` idles low and each bit has `HALF_DIV` clocks high and `HALF_DIV` clocks low. `mosi` changes only while `sclk` is low. `miso` is sampled as `sclk` rises, so a byte takes 8*`HALF_DIV` clocks of `sclk` high.
- R5: After each word, the received word is pushed to the RX queue. If the queue is full, the word is dropped and `stat_ovf` is set. A pulse on `stat_clr_ovf` clears it.
- R6: The selected channel is master when `cfg_master[cfg_chan_sel]` is 1. Without master status, no start condition has any effect. `cs_n` is low only on the selected channel, and only while it is master.
- R7: Chained mode holds when the channel is master, the immediate-start bit is 0, and `cfg_ss_ctl[cfg_chan_sel]` is 1. In this mode a finished burst flows straight into the next one, and the exchange bit is set again at each burst start.
- R8: When a burst's bit count reaches zero outside chained mode, the engine sets `stat_tc` and stops, even if TX words remain. The exchange bit stays as it was.
- R9: Whenever the engine finds the TX queue empty, it sets `stat_tc`, clears the exchange bit and stops.
- R10: A transfer starts on any of three events. The first is a TX push with the immediate-start bit set. The second is a control write that newly sets the immediate-start bit while the TX queue holds data. The third is a control write that newly sets the exchange bit with the immediate-start bit written 0.
- R11: `busy` is high from the cycle after a start until the engine stops. While `busy` is high, control writes are ignored entirely and TX pushes start nothing.
- R12: A TX push while the TX queue is full (depth `TX_DEPTH`) is dropped.
- R13: After reset, no transfer is running, both queues are empty, and `stat_tc`, `stat_ovf`, the exchange bit and `sclk` are all 0. A pulse on `stat_clr_tc` clears `stat_tc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_m1 | input | BURST_W | Burst length in bits minus one |
| cfg_chan_sel | input | $clog2(NUM_CH) | Selected channel |
| cfg_master | input | NUM_CH | Per-channel master enable |
| cfg_ss_ctl | input | NUM_CH | Per-channel chained-burst enable |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_smc | input | 1 | Immediate-start bit value written |
| ctrl_xch | input | 1 | Exchange bit value written |
| tx_we | input | 1 | TX queue push |
| tx_wdata | input | 32 | TX word |
| tx_full | output | 1 | TX queue full |
| tx_empty | output | 1 | TX queue empty |
| rx_re | input | 1 | RX queue pop |
| rx_rdata | output | 32 | Popped RX word, valid the cycle after `rx_re` |
| rx_valid | output | 1 | RX queue holds data |
| stat_clr_tc | input | 1 | Clear transfer-complete |
| stat_clr_ovf | input | 1 | Clear overflow |
| stat_tc | output | 1 | Transfer complete (sticky) |
| stat_ovf | output | 1 | RX overflow (sticky) |
| xch_o | output | 1 | Current exchange bit |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | NUM_CH | Active-low chip selects |

## Verification
A start request is accepted at the clock edge where its strobe is seen, so `busy` is high at the following sample point. The bench drives every strobe for one cycle between edges and checks `busy` right after. `stat_tc`, `stat_ovf` and the exchange bit change at the same edge where `busy` falls, so they are checked at the first sample after `busy` is seen low. Popped RX data is registered and is read one cycle after the pop strobe. The byte count and the count of `sclk`-high cycles are compared only after the engine has gone idle, against totals computed from the burst arithmetic.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int WB_W   = $clog2(WORD_W) + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LATCH,
    ST_SEND,
    ST_WAIT,
    ST_STORE
  } eng_state_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             do_wr, do_rd;

  assign empty = (cnt == '0);
  assign full  = (cnt == FULL_CNT);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R12: a push into a full queue leaves the occupancy unchanged
  a_r12_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> (cnt == FULL_CNT));

  // R5: popping an empty queue never changes the occupancy
  a_r5_empty_pop_noop: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en) |=> (cnt == '0));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DW = $clog2(HALF_DIV) + 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] dcnt;
  logic [2:0]    bitn;
  logic [7:0]    tx_sh;
  logic [7:0]    rx_sh;

  assign rx_byte = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      dcnt   <= '0;
      bitn   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          tx_sh  <= tx_byte;
          mosi   <= tx_byte[7];
          dcnt   <= '0;
          bitn   <= '0;
          sclk   <= 1'b0;
        end
      end else if (dcnt == DIV_LAST) begin
        dcnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn  <= bitn + 1'b1;
            tx_sh <= {tx_sh[6:0], 1'b0};
            mosi  <= tx_sh[6];
          end
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  // R4: the clock rests low whenever no byte is in flight
  a_r4_sclk_rests_low: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk);

  // R4: data out holds still through a high phase of sclk
  a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int BURST_W  = 12,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int HALF_DIV = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BURST_W-1:0]        cfg_burst_m1,
  input  logic [$clog2(NUM_CH)-1:0] cfg_chan_sel,
  input  logic [NUM_CH-1:0]         cfg_master,
  input  logic [NUM_CH-1:0]         cfg_ss_ctl,
  input  logic                      ctrl_we,
  input  logic                      ctrl_smc,
  input  logic                      ctrl_xch,
  input  logic                      tx_we,
  input  logic [31:0]               tx_wdata,
  output logic                      tx_full,
  output logic                      tx_empty,
  input  logic                      rx_re,
  output logic [31:0]               rx_rdata,
  output logic                      rx_valid,
  input  logic                      stat_clr_tc,
  input  logic                      stat_clr_ovf,
  output logic                      stat_tc,
  output logic                      stat_ovf,
  output logic                      xch_o,
  output logic                      busy,
  output logic                      sclk,
  output logic                      mosi,
  input  logic                      miso,
  output logic [NUM_CH-1:0]         cs_n
);
  localparam int RW = BURST_W + 1;

  eng_state_t        st;
  logic [RW-1:0]     rem_q;
  logic [WB_W-1:0]   wbits_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] rxacc_q;
  logic              smc_q, xch_q, tc_q, ovf_q;

  logic              is_master, multi, ctrl_acc, start_req;
  logic [RW-1:0]     ext_len, burst_bits, rem_eff;
  logic [WB_W-1:0]   first_bits;
  logic [WORD_W-1:0] shifted;
  logic              tx_pop, rx_push, rx_empty, rx_full;
  logic [WORD_W-1:0] tx_rdata;
  logic              sh_start, sh_active, sh_done;
  logic [7:0]        sh_rx;

  // channel qualification and burst arithmetic
  always_comb begin
    is_master  = cfg_master[cfg_chan_sel];
    multi      = is_master && !smc_q && cfg_ss_ctl[cfg_chan_sel];
    ext_len    = RW'(cfg_burst_m1) + RW'(1);
    burst_bits = (ext_len + RW'(7)) & ~RW'(7);
    rem_eff    = (rem_q == '0) ? burst_bits : rem_q;
    first_bits = (rem_eff[4:0] == 5'd0) ? WB_W'(WORD_W) : WB_W'(rem_eff[4:0]);
    shifted    = word_q >> (wbits_q - WB_W'(BYTE_W));
  end

  assign ctrl_acc  = ctrl_we && (st == ST_IDLE);
  assign start_req = (st == ST_IDLE) && is_master &&
                     ((tx_we && !tx_full && smc_q) ||
                      (ctrl_we && ctrl_smc && !smc_q && !tx_empty) ||
                      (ctrl_we && ctrl_xch && !xch_q && !ctrl_smc));

  assign tx_pop   = (st == ST_FETCH) && !tx_empty;
  assign rx_push  = (st == ST_STORE);
  assign sh_start = (st == ST_SEND);
  assign busy     = (st != ST_IDLE);
  assign rx_valid = !rx_empty;
  assign stat_tc  = tc_q;
  assign stat_ovf = ovf_q;
  assign xch_o    = xch_q;

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .wr_en(tx_we), .wr_data(tx_wdata),
    .rd_en(tx_pop), .rd_data(tx_rdata),
    .empty(tx_empty), .full(tx_full)
  );

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .wr_en(rx_push), .wr_data(rxacc_q),
    .rd_en(rx_re), .rd_data(rx_rdata),
    .empty(rx_empty), .full(rx_full)
  );

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst),
    .start(sh_start), .tx_byte(shifted[7:0]), .miso(miso),
    .sclk(sclk), .mosi(mosi), .active(sh_active),
    .done(sh_done), .rx_byte(sh_rx)
  );

  // per-channel select lines
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs_n[ch] <= 1'b1;
      else     cs_n[ch] <= !(is_master && (cfg_chan_sel == ($clog2(NUM_CH))'(ch)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rem_q   <= '0;
      wbits_q <= '0;
      word_q  <= '0;
      rxacc_q <= '0;
      smc_q   <= 1'b0;
      xch_q   <= 1'b0;
      tc_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (stat_clr_tc)  tc_q  <= 1'b0;
      if (stat_clr_ovf) ovf_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (ctrl_acc) begin
            smc_q <= ctrl_smc;
            xch_q <= ctrl_xch;
          end
          if (start_req) st <= ST_FETCH;
        end
        ST_FETCH: begin
          if (tx_empty) begin
            tc_q  <= 1'b1;
            xch_q <= 1'b0;
            st    <= ST_IDLE;
          end else begin
            if (rem_q == '0) begin
              rem_q <= burst_bits;
              if (multi) xch_q <= 1'b1;
            end
            wbits_q <= first_bits;
            rxacc_q <= '0;
            st      <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          word_q <= tx_rdata;
          st     <= ST_SEND;
        end
        ST_SEND: st <= ST_WAIT;
        ST_WAIT: begin
          if (sh_done) begin
            rxacc_q <= {rxacc_q[WORD_W-9:0], sh_rx};
            wbits_q <= wbits_q - WB_W'(BYTE_W);
            rem_q   <= rem_q - RW'(BYTE_W);
            st      <= (wbits_q == WB_W'(BYTE_W)) ? ST_STORE : ST_SEND;
          end
        end
        ST_STORE: begin
          if (rx_full) ovf_q <= 1'b1;
          if (rem_q == '0 && !multi) begin
            tc_q <= 1'b1;
            if (tx_empty) xch_q <= 1'b0;
            st <= ST_IDLE;
          end else begin
            st <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: no SPI clock activity while the engine is idle
  a_r11_idle_no_sclk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  // R9: the exchange bit drops only through a control write or an empty queue
  a_r9_xch_drop_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(xch_q) |-> ($past(ctrl_acc) || $past(tx_empty)));

  // R5: overflow is raised only when the RX queue was full
  a_r5_ovf_on_full: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(rx_full));

  // R2: a word's bit count is a non-zero byte multiple no larger than a word
  a_r2_word_bits_legal: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH) |-> (wbits_q != '0 && wbits_q[2:0] == 3'd0 &&
                          wbits_q <= WB_W'(WORD_W)));

  // R8: transfer-complete rises only as the engine returns to idle
  a_r8_tc_with_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(tc_q) |-> (st == ST_IDLE));

  // R6: a start is never taken for a channel that is not master
  a_r6_start_needs_master: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_IDLE && st == ST_FETCH) |-> $past(is_master));
endmodule

// File: tb/spi_burst_engine_tb.sv
module spi_burst_engine_tb;
  localparam int NUM_CH = 4, BURST_W = 12, TX_DEPTH = 8, RX_DEPTH = 8, HALF_DIV = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [BURST_W-1:0] cfg_burst_m1 = '0;
  logic [1:0] cfg_chan_sel = '0;
  logic [NUM_CH-1:0] cfg_master = '0, cfg_ss_ctl = '0;
  logic ctrl_we = 0, ctrl_smc = 0, ctrl_xch = 0, tx_we = 0, rx_re = 0;
  logic stat_clr_tc = 0, stat_clr_ovf = 0;
  logic [31:0] tx_wdata = '0, rx_rdata;
  logic tx_full, tx_empty, rx_valid, stat_tc, stat_ovf, xch_o, busy, sclk, mosi, miso;
  logic [NUM_CH-1:0] cs_n;

  spi_burst_engine #(.NUM_CH(NUM_CH), .BURST_W(BURST_W), .TX_DEPTH(TX_DEPTH),
                     .RX_DEPTH(RX_DEPTH), .HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rst(rst), .cfg_burst_m1(cfg_burst_m1), .cfg_chan_sel(cfg_chan_sel),
    .cfg_master(cfg_master), .cfg_ss_ctl(cfg_ss_ctl), .ctrl_we(ctrl_we),
    .ctrl_smc(ctrl_smc), .ctrl_xch(ctrl_xch), .tx_we(tx_we), .tx_wdata(tx_wdata),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_re(rx_re), .rx_rdata(rx_rdata),
    .rx_valid(rx_valid), .stat_clr_tc(stat_clr_tc), .stat_clr_ovf(stat_clr_ovf),
    .stat_tc(stat_tc), .stat_ovf(stat_ovf), .xch_o(xch_o), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, hi_cnt = 0;
  bit finished = 0;

  // slave model: response byte k is (37*k + 11) mod 256, MSB first
  int g = 0;
  function automatic logic [7:0] resp(int k);
    return 8'(k * 37 + 11);
  endfunction
  assign miso = resp(g / 8)[7 - (g % 8)];
  always @(negedge sclk) g = g + 1;

  logic [7:0] mshift = '0;
  int mbits = 0, nsent = 0;
  logic [7:0] sent [0:511];
  always @(posedge sclk) begin
    mshift = {mshift[6:0], mosi};
    mbits = mbits + 1;
    if (mbits % 8 == 0) begin
      sent[nsent] = mshift;
      nsent = nsent + 1;
    end
  end

  always @(negedge clk) if (sclk) hi_cnt = hi_cnt + 1;

  // bench model state
  logic [31:0] tw [0:63];
  int tw_wr = 0, tw_rd = 0, rem_m = 0;
  logic [7:0]  eb [0:511];
  logic [31:0] er [0:63];
  logic [31:0] keep [0:63];
  int ne = 0, nr = 0, base = 0, hi0 = 0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc >= 150000 && !finished) begin
      finished = 1;
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctrl_write(input logic smc, input logic xch);
    @(negedge clk); ctrl_we = 1; ctrl_smc = smc; ctrl_xch = xch;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic push_tx(input logic [31:0] w);
    @(negedge clk); tx_we = 1; tx_wdata = w;
    if (tw_wr - tw_rd < TX_DEPTH) begin
      tw[tw_wr] = w;
      tw_wr = tw_wr + 1;
    end
    @(negedge clk); tx_we = 0;
  endtask

  task automatic pop_rx(output logic [31:0] w);
    @(negedge clk); rx_re = 1;
    @(negedge clk); rx_re = 0; w = rx_rdata;
  endtask

  task automatic clear_tc();
    @(negedge clk); stat_clr_tc = 1;
    @(negedge clk); stat_clr_tc = 0;
  endtask

  // arithmetic model of one exchange (R1 R2 R3 R7 R8)
  task automatic begin_run(input int bb, input bit multi);
    int wb;
    logic [31:0] w, acc;
    base = nsent; hi0 = hi_cnt; ne = 0; nr = 0;
    while (tw_rd < tw_wr) begin
      if (rem_m == 0) rem_m = bb;
      wb = (rem_m % 32 != 0) ? rem_m % 32 : 32;
      w = tw[tw_rd]; tw_rd = tw_rd + 1; acc = 0;
      while (wb > 0) begin
        eb[ne] = 8'(w >> (wb - 8));
        acc = (acc << 8) | 32'(resp(base + ne));
        ne = ne + 1; wb = wb - 8; rem_m = rem_m - 8;
      end
      er[nr] = acc; nr = nr + 1;
      if (rem_m == 0 && !multi) break;
    end
  endtask

  task automatic finish_run(input string tag, input logic exp_xch, input bit do_pop);
    logic [31:0] w;
    int guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard = guard + 1; end
    check({tag, " R11 busy clears"}, 32'(busy), 0);
    check({tag, " R3 byte count"}, nsent - base, ne);
    for (int i = 0; i < ne; i++) check({tag, " R3 mosi byte"}, 32'(sent[base + i]), 32'(eb[i]));
    check({tag, " R4 sclk high cycles"}, hi_cnt - hi0, ne * 8 * HALF_DIV);
    check({tag, " R8 R9 tc set"}, 32'(stat_tc), 1);
    check({tag, " R9 xch after stop"}, 32'(xch_o), 32'(exp_xch));
    check({tag, " R2 tx left"}, 32'(tx_empty), 32'(tw_rd == tw_wr));
    if (do_pop) begin
      for (int i = 0; i < nr; i++) begin
        pop_rx(w);
        check({tag, " R3 R5 rx word"}, w, er[i]);
      end
      check({tag, " R5 rx drained"}, 32'(rx_valid), 0);
    end
    clear_tc();
    check({tag, " R13 tc cleared"}, 32'(stat_tc), 0);
  endtask

  initial begin
    int fields [12] = '{0, 7, 8, 15, 23, 31, 32, 39, 63, 71, 95, 127};
    int bb, nw, s0;
    logic [31:0] w;
    cyc_n(4);
    rst = 0;
    cyc_n(2);
    // R13 reset state
    check("R13 busy", 32'(busy), 0);
    check("R13 tc", 32'(stat_tc), 0);
    check("R13 ovf", 32'(stat_ovf), 0);
    check("R13 tx_empty", 32'(tx_empty), 1);
    check("R13 rx_valid", 32'(rx_valid), 0);
    check("R13 xch", 32'(xch_o), 0);
    check("R13 sclk", 32'(sclk), 0);
    check("R6 cs_n idle", 32'(cs_n), 32'hF);

    cfg_chan_sel = 2'd1; cfg_master = 4'b0010; cfg_ss_ctl = 4'b0000;
    cyc_n(2);
    check("R6 cs_n selected", 32'(cs_n), 32'hD);

    // R1 R2 R3 R10: sweep of burst lengths, started by the exchange bit
    foreach (fields[k]) begin
      cfg_burst_m1 = BURST_W'(fields[k]);
      bb = ((fields[k] + 1 + 7) / 8) * 8;
      nw = (bb + 31) / 32;
      for (int i = 0; i < nw; i++) push_tx(32'h9E3779B9 * 32'(k * 5 + i + 1));
      check("R10 no start without request", 32'(busy), 0);
      ctrl_write(0, 1);
      check("R10 R11 xch start busy", 32'(busy), 1);
      begin_run(bb, 0);
      finish_run("R1 sweep", 0, 1);
    end

    // R8: burst ends with a word still queued
    cfg_burst_m1 = 12'd15;
    push_tx(32'h11223344); push_tx(32'h55667788);
    ctrl_write(0, 1);
    begin_run(16, 0);
    finish_run("R8 early stop", 1, 1);
    ctrl_write(0, 1);
    check("R10 xch not newly set", 32'(busy), 0);
    ctrl_write(0, 0);
    ctrl_write(0, 1);
    check("R10 xch restart", 32'(busy), 1);
    begin_run(16, 0);
    finish_run("R8 resume", 0, 1);

    // R7: chained bursts of 40 bits over three words
    cfg_ss_ctl = 4'b0010; cfg_burst_m1 = 12'd39;
    push_tx(32'hA5A5A5C3); push_tx(32'hDEADBEEF); push_tx(32'h0BADF00D);
    ctrl_write(0, 0);
    ctrl_write(0, 1);
    begin_run(40, 1);
    cyc_n(40);
    check("R7 xch held during chain", 32'(xch_o), 1);
    check("R7 busy during chain", 32'(busy), 1);
    finish_run("R7 chained", 0, 1);

    // R10: immediate-start mode
    cfg_ss_ctl = 4'b0000; cfg_burst_m1 = 12'd31;
    ctrl_write(1, 0);
    check("R10 smc with empty queue", 32'(busy), 0);
    push_tx(32'hCAFEF00D);
    check("R10 push starts", 32'(busy), 1);
    begin_run(32, 0);
    push_tx(32'h13579BDF);
    finish_run("R10 push run", 0, 1);
    check("R8 word waits", 32'(tx_empty), 0);
    ctrl_write(0, 0);
    check("R10 smc clear no start", 32'(busy), 0);
    ctrl_write(1, 0);
    check("R10 smc newly set starts", 32'(busy), 1);
    begin_run(32, 0);
    finish_run("R10 smc run", 0, 1);

    // R12 R5: full TX queue, then RX overflow
    ctrl_write(0, 0);
    cfg_ss_ctl = 4'b0010; cfg_burst_m1 = 12'd7;
    for (int i = 0; i < TX_DEPTH; i++) push_tx(32'h01000000 * 32'(i) + 32'h40 + 32'(i));
    check("R12 tx full", 32'(tx_full), 1);
    push_tx(32'hFFFFFFFF);
    ctrl_write(0, 1);
    begin_run(8, 1);
    for (int i = 0; i < nr; i++) keep[i] = er[i];
    finish_run("R12 full drop", 0, 0);
    check("R5 no ovf yet", 32'(stat_ovf), 0);
    push_tx(32'h000000E7);
    ctrl_write(0, 1);
    begin_run(8, 1);
    finish_run("R5 overflow run", 0, 0);
    check("R5 ovf set", 32'(stat_ovf), 1);
    for (int i = 0; i < RX_DEPTH; i++) begin
      pop_rx(w);
      check("R5 kept word", w, keep[i]);
    end
    check("R5 dropped word absent", 32'(rx_valid), 0);
    @(negedge clk); stat_clr_ovf = 1;
    @(negedge clk); stat_clr_ovf = 0;
    check("R13 ovf cleared", 32'(stat_ovf), 0);

    // R6: channel not master ignores start
    cfg_ss_ctl = 4'b0000; cfg_master = 4'b0001; cfg_burst_m1 = 12'd31;
    push_tx(32'h87654321);
    ctrl_write(0, 0);
    ctrl_write(0, 1);
    check("R6 non-master no start", 32'(busy), 0);
    s0 = nsent;
    cyc_n(50);
    check("R6 non-master no bytes", nsent - s0, 0);
    check("R6 cs_n none", 32'(cs_n), 32'hF);
    cfg_chan_sel = 2'd0;
    cyc_n(2);
    check("R6 cs_n ch0", 32'(cs_n), 32'hE);
    ctrl_write(0, 0);
    ctrl_write(0, 1);
    check("R6 master start", 32'(busy), 1);
    begin_run(32, 0);
    ctrl_write(1, 0);
    finish_run("R6 ch0 run", 0, 1);

    // R11: the control write made while busy was dropped, so smc is still 0
    s0 = nsent;
    push_tx(32'h2468ACE0);
    cyc_n(2);
    check("R11 busy write ignored", 32'(busy), 0);
    cyc_n(50);
    check("R11 no bytes", nsent - s0, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule